// File: doc/BRIEF.md
# Character Display Command Engine

This block is the controller half of a character-display module. A host writes instruction bytes or data bytes into it and reads back either a status byte or stored characters. It decodes each instruction and keeps the mode flags, a 7-bit address counter and a horizontal display-shift offset. It also holds an 80-entry character store laid out as two 40-character lines and a 64-byte glyph-pattern store. Each accepted operation raises a busy flag for a fixed execution time. The length of that time is a parameter counted in clock cycles.

A host polls the status byte until the busy bit clears, then issues the next instruction or data transfer. Instruction bytes are classified by their most significant set bit, so the low bits act as arguments for that instruction. Data transfers go to whichever store the last address instruction selected. After each transfer the counter steps according to the entry mode, and on the character store it jumps across the unused hole between the two lines.

Top module: `lcd_cmd_engine`

## Requirements
- R1: After reset, busy is 0, the address counter is 0x00, the shift offset is 0, disp_ctrl and func_cfg are 0, the entry mode is increment without shift, the character store holds 0x20 everywhere, and data transfers target the character store.
- R2: An instruction byte is classified by its highest set bit: bit7 sets the character address (bits 6..0), bit6 sets the glyph address (bits 5..0), bit5 is function set, bit4 is cursor/display shift, bit3 is display control, bit2 is entry mode, bit1 is return home, bit0 alone is clear. The byte 0x00 does nothing and raises no busy.
- R3: Clear and return home hold busy for LONG_US*CLKS_PER_US cycles. Every other instruction, and every accepted data write or data read, holds busy for SHORT_US*CLKS_PER_US cycles, starting the cycle after acceptance. A status read adds no busy time.
- R4: While busy is 1, instruction writes, data writes and data reads are ignored. Status reads are still served.
- R5: A status read (rd_en with sel_data=0) returns busy in bit 7 and the address counter in bits 6..0.
- R6: Clear fills the character store with 0x20, sets the counter to 0x00, sets the shift offset to 0 and selects the character store.
- R7: Return home sets the counter to 0x00 and the shift offset to 0. Store contents are left unchanged.
- R8: Entry mode takes bit1 as the direction (1 = increment) and bit0 as the shift enable. With shift enabled, each data transfer also moves the offset by +1 when incrementing or by -1 when decrementing, modulo 40.
- R9: On the character store, incrementing goes from 0x27 to 0x40 and from 0x67 to 0x00. Decrementing goes from 0x40 to 0x27 and from 0x00 to 0x67. A write to an address outside both lines is discarded, and a read there returns 0x00.
- R10: In the shift instruction, bit3=1 moves the display offset (bit2=0 left, +1; bit2=1 right, -1; modulo 40). Bit3=0 moves the counter one step (bit2=1 forward, bit2=0 back). Neither form changes stored data.
- R11: Display control loads disp_ctrl from instruction bits 2..0. Function set loads func_cfg from instruction bits 4..2.
- R12: After a glyph address instruction, data transfers use the 64-byte glyph store and the counter wraps modulo 64 within bits 5..0, with bit 6 reading 0. The character store is untouched.
- R13: rd_valid is 1 for exactly the cycle after an accepted read, with rd_byte holding the result. A write in the same cycle as a read takes priority and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| sel_data | input | 1 | 1 = data access, 0 = instruction/status |
| wr_byte | input | 8 | Instruction or data byte |
| rd_byte | output | 8 | Status or read data |
| rd_valid | output | 1 | rd_byte holds a fresh result |
| busy | output | 1 | Execution in progress |
| disp_ctrl | output | 3 | Display, cursor, blink enables |
| func_cfg | output | 3 | Bus width, line count, font flags |
| shift_ofs | output | 6 | Display shift offset, 0..39 |

## Verification
Several rules are checked on every clock by the in-line assertions. Every accepted operation raises busy, and a status read on an idle engine leaves it idle. Clear and home zero the counter and the offset. A step on the character store never lands in the hole between the lines, and the offset stays below 40. Instructions offered while busy leave the flags unchanged, and rd_valid follows exactly one cycle after each accepted read. The exact busy lengths, the ignored data write landing nowhere, the retention of contents across home, the fill on clear, the glyph-store wrap and the separation of the two stores depend on stored data and counts. Only the scoreboard scenarios can show these, by reading the data back.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  localparam int LINE_LEN = 40;
  localparam logic [6:0] LINE1_END = 7'h27;
  localparam logic [6:0] LINE2_BASE = 7'h40;
  localparam logic [6:0] LINE2_END = 7'h67;

  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_SHIFT, OP_FUNC, OP_CGADR, OP_DDADR
  } op_e;

  function automatic op_e decode_op(input logic [7:0] b);
    op_e r;
    casez (b)
      8'b1???????: r = OP_DDADR;
      8'b01??????: r = OP_CGADR;
      8'b001?????: r = OP_FUNC;
      8'b0001????: r = OP_SHIFT;
      8'b00001???: r = OP_DISP;
      8'b000001??: r = OP_ENTRY;
      8'b0000001?: r = OP_HOME;
      8'b00000001: r = OP_CLEAR;
      default:     r = OP_NONE;
    endcase
    return r;
  endfunction

  function automatic logic dd_ok(input logic [6:0] a);
    return (a <= LINE1_END) || (a >= LINE2_BASE && a <= LINE2_END);
  endfunction

  function automatic logic [6:0] dd_index(input logic [6:0] a);
    return (a < LINE2_BASE) ? a : (a - LINE2_BASE + 7'(LINE_LEN));
  endfunction

  function automatic logic [6:0] dd_step(input logic [6:0] a, input logic up);
    logic [6:0] r;
    if (up) begin
      if (a >= LINE2_END)                          r = 7'h00;
      else if (a >= LINE1_END && a < LINE2_BASE)   r = LINE2_BASE;
      else                                         r = a + 7'd1;
    end else begin
      if (a == 7'h00 || a > LINE2_END)             r = LINE2_END;
      else if (a > LINE1_END && a <= LINE2_BASE)   r = LINE1_END;
      else                                         r = a - 7'd1;
    end
    return r;
  endfunction

  function automatic logic [5:0] ofs_step(input logic [5:0] o, input logic left);
    logic [5:0] r;
    if (left) r = (o >= 6'(LINE_LEN - 1)) ? 6'd0 : o + 6'd1;
    else      r = (o == 6'd0) ? 6'(LINE_LEN - 1) : o - 6'd1;
    return r;
  endfunction

endpackage

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= load;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && (load != '0) |=> busy); // R3

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy); // R3
endmodule

// File: rtl/lcd_char_store.sv
module lcd_char_store
  import lcd_cmd_pkg::*;
#(
  parameter int CG_DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       we,
  input  logic       cg_sel,
  input  logic [6:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int DD_DEPTH = 2 * LINE_LEN;
  localparam int CGW = $clog2(CG_DEPTH);

  logic [7:0] dd_mem [DD_DEPTH];
  logic [7:0] cg_mem [CG_DEPTH];

  logic [6:0]     dd_idx;
  logic           dd_hit;
  logic [CGW-1:0] cg_idx;

  assign dd_idx = dd_index(addr);
  assign dd_hit = dd_ok(addr);
  assign cg_idx = addr[CGW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= 8'h20;
      for (int i = 0; i < CG_DEPTH; i++) cg_mem[i] <= 8'h00;
    end else if (clr) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= 8'h20;
    end else if (we) begin
      if (cg_sel)      cg_mem[cg_idx] <= wdata;
      else if (dd_hit) dd_mem[dd_idx] <= wdata;
    end
  end

  always_comb begin
    if (cg_sel)      rdata = cg_mem[cg_idx];
    else if (dd_hit) rdata = dd_mem[dd_idx];
    else             rdata = 8'h00;
  end
endmodule

// File: rtl/lcd_cmd_engine.sv
module lcd_cmd_engine
  import lcd_cmd_pkg::*;
#(
  parameter int CLKS_PER_US = 1,
  parameter int SHORT_US    = 40,
  parameter int LONG_US     = 1640
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       sel_data,
  input  logic [7:0] wr_byte,
  output logic [7:0] rd_byte,
  output logic       rd_valid,
  output logic       busy,
  output logic [2:0] disp_ctrl,
  output logic [2:0] func_cfg,
  output logic [5:0] shift_ofs
);
  localparam int SHORT_CYC = SHORT_US * CLKS_PER_US;
  localparam int LONG_CYC  = LONG_US * CLKS_PER_US;
  localparam int TW        = $clog2(LONG_CYC + 1);

  // named events
  logic inst_wr, data_wr, data_rd, stat_rd, cmd_go, step_evt, long_cmd;
  op_e  op;

  logic [6:0] ac;
  logic       tgt_cg;
  logic       inc_dir, auto_shift;
  logic [7:0] store_rd;
  logic [TW-1:0] busy_load;

  assign op       = decode_op(wr_byte);
  assign inst_wr  = wr_en && !busy && !sel_data;
  assign data_wr  = wr_en && !busy && sel_data;
  assign data_rd  = rd_en && !wr_en && sel_data && !busy;
  assign stat_rd  = rd_en && !wr_en && !sel_data;
  assign cmd_go   = inst_wr && (op != OP_NONE);
  assign step_evt = data_wr || data_rd;
  assign long_cmd = (op == OP_CLEAR) || (op == OP_HOME);
  assign busy_load = (cmd_go && long_cmd) ? TW'(LONG_CYC) : TW'(SHORT_CYC);

  function automatic logic [6:0] ac_step(input logic [6:0] a, input logic cg,
                                         input logic up);
    logic [6:0] r;
    if (cg) r = {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
    else    r = dd_step(a, up);
    return r;
  endfunction

  lcd_busy_timer #(.CW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cmd_go || step_evt),
    .load  (busy_load),
    .busy  (busy)
  );

  lcd_char_store #(.CG_DEPTH(64)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cmd_go && (op == OP_CLEAR)),
    .we     (data_wr),
    .cg_sel (tgt_cg),
    .addr   (ac),
    .wdata  (wr_byte),
    .rdata  (store_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac         <= 7'h00;
      tgt_cg     <= 1'b0;
      inc_dir    <= 1'b1;
      auto_shift <= 1'b0;
      disp_ctrl  <= 3'b000;
      func_cfg   <= 3'b000;
      shift_ofs  <= 6'd0;
    end else if (cmd_go) begin
      case (op)
        OP_CLEAR, OP_HOME: begin
          ac        <= 7'h00;
          shift_ofs <= 6'd0;
          if (op == OP_CLEAR) tgt_cg <= 1'b0;
        end
        OP_ENTRY: begin
          inc_dir    <= wr_byte[1];
          auto_shift <= wr_byte[0];
        end
        OP_DISP: disp_ctrl <= wr_byte[2:0];
        OP_SHIFT: begin
          if (wr_byte[3]) shift_ofs <= ofs_step(shift_ofs, !wr_byte[2]);
          else            ac <= ac_step(ac, tgt_cg, wr_byte[2]);
        end
        OP_FUNC: func_cfg <= wr_byte[4:2];
        OP_CGADR: begin
          ac     <= {1'b0, wr_byte[5:0]};
          tgt_cg <= 1'b1;
        end
        OP_DDADR: begin
          ac     <= wr_byte[6:0];
          tgt_cg <= 1'b0;
        end
        default: ;
      endcase
    end else if (step_evt) begin
      ac <= ac_step(ac, tgt_cg, inc_dir);
      if (auto_shift) shift_ofs <= ofs_step(shift_ofs, inc_dir);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_byte  <= 8'h00;
    end else begin
      rd_valid <= data_rd || stat_rd;
      if (stat_rd)      rd_byte <= {busy, ac};
      else if (data_rd) rd_byte <= store_rd;
    end
  end

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go || step_evt) |=> busy); // R3

  AST_STATUS_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !busy |=> !busy); // R3

  AST_HOME_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && long_cmd |=> (ac == 7'h00) && (shift_ofs == 6'd0)); // R7

  AST_NO_GAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && !tgt_cg |=> dd_ok(ac)); // R9

  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ofs < 6'(LINE_LEN)); // R8

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> $stable(disp_ctrl) && $stable(func_cfg)); // R4

  AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd || stat_rd) |=> rd_valid); // R13

  AST_RD_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_rd || stat_rd) |=> !rd_valid); // R13
endmodule

// File: tb/sim_lcd_cmd_engine.sv
module sim_lcd_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_N = 40;
  localparam int LONG_N  = 1640;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, sel_data = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] rd_byte;
  logic rd_valid, busy;
  logic [2:0] disp_ctrl, func_cfg;
  logic [5:0] shift_ofs;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .sel_data(sel_data), .wr_byte(wr_byte), .rd_byte(rd_byte),
    .rd_valid(rd_valid), .busy(busy), .disp_ctrl(disp_ctrl),
    .func_cfg(func_cfg), .shift_ofs(shift_ofs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare each delivered read with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R13 unexpected rd_valid", rd_byte, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_byte == e, t, rd_byte, e);
      end
    end
  end

  task automatic put(input bit sd, input logic [7:0] b);
    @(negedge clk);
    sel_data = sd; wr_byte = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get(input bit sd, input logic [7:0] e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk);
    sel_data = sd; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    put(1'b0, b);
    idle();
  endtask

  task automatic wrd(input logic [7:0] b);
    put(1'b1, b);
    idle();
  endtask

  task automatic rdd(input logic [7:0] e, input string req);
    get(1'b1, e, req);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(shift_ofs == 6'd0, "R1 shift", shift_ofs, 0);
    chk(disp_ctrl == 3'd0 && func_cfg == 3'd0, "R1 flags", {disp_ctrl, func_cfg}, 0);
    get(1'b0, 8'h00, "R1 R5 status after reset");
    rdd(8'h20, "R1 store holds space");

    // R3 short busy, R11 function set
    put(1'b0, 8'h38);
    busy_len(n);
    chk(n == SHORT_N, "R3 short busy", n, SHORT_N);
    chk(func_cfg == 3'b110, "R11 func_cfg", func_cfg, 3'b110);
    cmd(8'h0F);
    chk(disp_ctrl == 3'b111, "R11 disp_ctrl", disp_ctrl, 3'b111);
    cmd(8'h0C);
    chk(disp_ctrl == 3'b100, "R11 disp_ctrl 2", disp_ctrl, 3'b100);

    // R9 line hop upward
    cmd(8'h06);
    cmd(8'hA6);
    wrd(8'h41); wrd(8'h42); wrd(8'h43);
    get(1'b0, 8'h41, "R9 counter after 0x27 step");
    cmd(8'hA6);
    rdd(8'h41, "R9 data at 0x26");
    rdd(8'h42, "R9 data at 0x27");
    rdd(8'h43, "R9 data at 0x40");
    get(1'b1, 8'h20, "R3 data read");
    busy_len(n);
    chk(n == SHORT_N, "R3 busy after data read", n, SHORT_N);

    // R4 ignored while busy, R5 status during busy
    cmd(8'h80);
    put(1'b1, 8'h58);
    put(1'b1, 8'h59);
    put(1'b0, 8'h38 ^ 8'h04);
    get(1'b0, 8'h81, "R4 R5 status while busy");
    idle();
    chk(func_cfg == 3'b110, "R4 instruction ignored", func_cfg, 3'b110);
    cmd(8'h80);
    rdd(8'h58, "R4 first write kept");
    rdd(8'h20, "R4 busy write dropped");

    // R9 downward hops
    cmd(8'h04);
    cmd(8'hC0);
    wrd(8'h44);
    get(1'b0, 8'h27, "R9 0x40 down to 0x27");
    cmd(8'h80);
    wrd(8'h45);
    get(1'b0, 8'h67, "R9 0x00 down to 0x67");

    // R8 entry shift
    cmd(8'h90);
    cmd(8'h07);
    wrd(8'h55);
    chk(shift_ofs == 6'd1, "R8 shift on inc", shift_ofs, 1);
    cmd(8'h05);
    wrd(8'h55);
    chk(shift_ofs == 6'd0, "R8 shift on dec", shift_ofs, 0);
    wrd(8'h55);
    chk(shift_ofs == 6'd39, "R8 shift wrap", shift_ofs, 39);

    // R10 shift instruction
    cmd(8'h18);
    chk(shift_ofs == 6'd0, "R10 display left", shift_ofs, 0);
    cmd(8'h1C);
    chk(shift_ofs == 6'd39, "R10 display right", shift_ofs, 39);
    cmd(8'hA7);
    cmd(8'h14);
    get(1'b0, 8'h40, "R10 cursor right hop");
    cmd(8'h10);
    get(1'b0, 8'h27, "R10 cursor left hop");
    chk(shift_ofs == 6'd39, "R10 cursor move keeps offset", shift_ofs, 39);

    // R7 home
    put(1'b0, 8'h02);
    busy_len(n);
    chk(n == LONG_N, "R3 long busy home", n, LONG_N);
    chk(shift_ofs == 6'd0, "R7 offset cleared", shift_ofs, 0);
    get(1'b0, 8'h00, "R7 counter home");
    rdd(8'h45, "R7 contents kept");

    // R6 clear
    cmd(8'h18);
    put(1'b0, 8'h01);
    busy_len(n);
    chk(n == LONG_N, "R3 long busy clear", n, LONG_N);
    chk(shift_ofs == 6'd0, "R6 offset cleared", shift_ofs, 0);
    get(1'b0, 8'h00, "R6 counter cleared");
    rdd(8'h20, "R6 0x00 filled");
    cmd(8'hC0);
    rdd(8'h20, "R6 0x40 filled");

    // R12 glyph store
    cmd(8'h06);
    cmd(8'h7F);
    wrd(8'h15); wrd(8'h0A);
    get(1'b0, 8'h01, "R12 glyph counter wraps");
    cmd(8'h7F);
    rdd(8'h15, "R12 glyph 0x3F");
    rdd(8'h0A, "R12 glyph 0x00");
    cmd(8'h80);
    rdd(8'h20, "R12 character store untouched");

    // R2 null byte
    put(1'b0, 8'h00);
    chk(busy == 1'b0, "R2 zero byte no busy", busy, 0);
    get(1'b0, 8'h01, "R2 zero byte no effect");

    // R9 gap address
    cmd(8'hB0);
    wrd(8'h77);
    get(1'b0, 8'h40, "R9 gap step to line 2");
    cmd(8'hB0);
    rdd(8'h00, "R9 gap read");

    // R13 write wins over read
    @(negedge clk);
    sel_data = 1'b0; wr_byte = 8'h00; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, "R13 all reads delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule